// File: doc/BRIEF.md
# Group Dimming and Blinking Modulator

This block generates a single gating signal that is shared by every LED output running in group mode. A fast per-channel PWM elsewhere sets each output's own brightness. This gate is ANDed on top of that PWM, so a whole bank can be dimmed or blinked by one setting.

The block has two behaviours, chosen by a mode bit. In dim mode the gate is a slow PWM. It has a fixed period of 256 phase steps, and each step lasts `DIM_DIV` base ticks. With the default divider and a tick of about 97 kHz, this gives a rate near 190 Hz. In blink mode the gate is an on/off pattern. Each of the 256 phase steps lasts `BLINK_DIV * (freq + 1)` base ticks, so the 8-bit frequency value stretches the period from its shortest to its longest setting.

In both modes the gate is high while the 8-bit phase is strictly below the active duty value. The on-time is therefore duty/256 of the period. A write to the duty or frequency register goes into a shadow register and becomes active at the next wrap of the phase. A write that changes the mode restarts the pattern from phase 0 with cleared prescalers and loads the pending shadow values at once.

Top module: `group_gate_mod`

## Requirements
- R1: After reset the duty register holds FFh, the frequency register holds 00h and the mode is dim (0); the gate is high during and right after reset.
- R2: In dim mode the gate period is 256*DIM_DIV base ticks and the gate is high for duty*DIM_DIV ticks of it, starting at phase 0.
- R3: A duty of 00h keeps the gate low for the whole period; a duty of FFh keeps it high for all but the last phase step (255 of 256 steps).
- R4: In dim mode the frequency register has no effect on the gate.
- R5: In blink mode the period is 256*BLINK_DIV*(freq+1) base ticks and the on-time is duty*BLINK_DIV*(freq+1) ticks.
- R6: A duty or frequency write (wr_sel 00b = duty, 01b = frequency, 10b = mode in wr_data bit 0, 11b = no register) becomes active only at the next phase wrap; the period in progress keeps the old value.
- R7: A write that changes the mode clears the phase and the prescalers, so the new pattern starts at phase 0; pending duty and frequency values become active at that edge.
- R8: The phase advances only on clock edges where base_tick is high; with base_tick held low the gate holds its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_tick | input | 1 | Clock enable at the individual PWM period rate |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 00 duty, 01 frequency, 10 mode, 11 none |
| wr_data | input | 8 | Write data |
| gate | output | 1 | Group gate, high = outputs enabled |

## Verification
The in-line assertions check the following on every cycle:
- the phase moves by at most one step, or to zero;
- the phase never moves on an edge without a tick, unless the mode changed;
- the active duty changes only where the phase sits at zero;
- a mode change always leaves the phase and prescaler cleared;
- the blink hold counter stays idle in dim mode.

Only the bench's scenarios can show the on-times and periods of the gate: for several duty and frequency values in both modes, with deferred duty updates, with a frequency value that must be ignored, and with ticks that are sparse or stopped.

// File: rtl/group_gate_mod.sv
module group_gate_mod #(
  parameter int DIM_DIV   = 2,
  parameter int BLINK_DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_tick,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic       gate
);
  localparam int DIV_MAX = (DIM_DIV > BLINK_DIV) ? DIM_DIV : BLINK_DIV;
  localparam int PW      = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;
  localparam logic [PW-1:0] DIM_LAST   = PW'(DIM_DIV - 1);
  localparam logic [PW-1:0] BLINK_LAST = PW'(BLINK_DIV - 1);

  logic [7:0]    duty_sh, freq_sh, duty_act, freq_act;
  logic [7:0]    phase_q, hold_q;
  logic [PW-1:0] pre_q;
  logic          mode_q;

  wire wr_duty   = wr_en && (wr_sel == 2'd0);
  wire wr_freq   = wr_en && (wr_sel == 2'd1);
  wire mode_flip = wr_en && (wr_sel == 2'd2) && (wr_data[0] != mode_q);

  wire [PW-1:0] pre_last = mode_q ? BLINK_LAST : DIM_LAST;
  wire pre_done = base_tick && (pre_q == pre_last);
  wire step     = pre_done && (!mode_q || (hold_q == freq_act));
  wire wrap     = step && (phase_q == 8'hFF);

  assign gate = phase_q < duty_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_sh  <= 8'hFF;
      freq_sh  <= 8'h00;
      duty_act <= 8'hFF;
      freq_act <= 8'h00;
      mode_q   <= 1'b0;
      phase_q  <= 8'h00;
      hold_q   <= 8'h00;
      pre_q    <= '0;
    end else begin
      if (wr_duty) duty_sh <= wr_data;
      if (wr_freq) freq_sh <= wr_data;
      if (mode_flip) begin
        mode_q   <= wr_data[0];
        phase_q  <= 8'h00;
        hold_q   <= 8'h00;
        pre_q    <= '0;
        duty_act <= duty_sh;
        freq_act <= freq_sh;
      end else begin
        if (base_tick) pre_q <= pre_done ? '0 : pre_q + 1'b1;
        if (pre_done && mode_q) hold_q <= (hold_q == freq_act) ? 8'h00 : hold_q + 8'd1;
        if (step) phase_q <= phase_q + 8'd1;
        if (wrap) begin
          duty_act <= duty_sh;
          freq_act <= freq_sh;
        end
      end
    end
  end

  // R2: phase moves by one step or restarts at zero
  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_q) |-> (phase_q == $past(phase_q) + 8'd1 || phase_q == 8'h00));

  // R8: no tick and no mode change means the phase holds
  assert_no_tick_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(base_tick) && !$past(mode_flip)) |-> $stable(phase_q));

  // R6: active duty only changes where a new period begins
  assert_duty_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_act) |-> (phase_q == 8'h00));

  // R7: a mode change restarts phase and prescaler
  assert_flip_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_flip) |-> (phase_q == 8'h00 && pre_q == '0 && hold_q == 8'h00));

  // R4: blink hold counter stays idle in dim mode
  assert_dim_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (hold_q == 8'h00));
endmodule

// File: tb/tb_group_gate_mod.sv
module tb_group_gate_mod;
  localparam int CLK_PERIOD = 10;
  localparam int DD = 2;
  localparam int BD = 3;

  logic clk = 1'b0, rst_n = 1'b0, base_tick = 1'b1, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic gate;

  group_gate_mod #(.DIM_DIV(DD), .BLINK_DIV(BD)) dut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .gate(gate));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int on; int per; bit chk_first; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  int tick_cfg = 0;
  bit go = 0, busy = 0, done = 0;

  always @(negedge clk) begin
    if (tick_cfg == 0) base_tick = 1'b1;
    else if (tick_cfg == 1) base_tick = ~base_tick;
    else base_tick = 1'b0;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    if (go) begin
      busy = 1; go = 0;
      while (q.size() > 0) begin
        item_t it;
        int on;
        it = q.pop_front();
        on = 0;
        for (int i = 0; i < it.per; i++) begin
          @(negedge clk);
          if (i == 0 && it.chk_first) chk({it.tag, " first"}, int'(gate), int'(it.on > 0));
          if (gate) on++;
        end
        if (it.on >= 0) chk({it.tag, " on-time"}, on, it.on);
      end
      busy = 0;
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic push(input int on, input int per, input bit f, input string tag);
    item_t it;
    it.on = on; it.per = per; it.chk_first = f; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic kick(input bit m);
    wr(2'd2, {7'd0, ~m});
    @(negedge clk); wr_en = 1; wr_sel = 2'd2; wr_data = {7'd0, m}; go = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic settle();
    wait (!go && !busy);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 gate in reset", int'(gate), 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 gate after reset", int'(gate), 1);

    wr(2'd0, 8'd100); push(100*DD, 256*DD, 1, "R2 dim duty 100"); kick(0); settle();
    wr(2'd0, 8'd0);   push(0, 256*DD, 1, "R3 duty 00");          kick(0); settle();
    wr(2'd0, 8'hFF);  push(255*DD, 256*DD, 1, "R3 duty FF");     kick(0); settle();
    wr(2'd1, 8'd9); wr(2'd0, 8'd77);
    push(77*DD, 256*DD, 1, "R4 dim ignores freq");                kick(0); settle();

    wr(2'd1, 8'd0); wr(2'd0, 8'd128);
    push(128*BD, 256*BD, 1, "R5 blink f0");                       kick(1); settle();
    wr(2'd1, 8'd2); wr(2'd0, 8'd50);
    push(50*BD*3, 256*BD*3, 1, "R5 blink f2");                    kick(1); settle();

    wr(2'd0, 8'd64);
    push(64*DD, 256*DD, 1, "R6 old duty kept");
    push(200*DD, 256*DD, 1, "R6 new duty at wrap");
    kick(0);
    repeat (10) @(negedge clk);
    wr(2'd0, 8'd200);
    settle();

    wr(2'd0, 8'd30);
    push(30*DD, 256*DD, 1, "R7 pending loaded on flip");          kick(0); settle();

    tick_cfg = 1;
    wr(2'd0, 8'd100);
    push(-1, 512*DD, 0, "R8 half ticks warmup");
    push(100*DD*2, 512*DD, 0, "R8 half-rate ticks");
    kick(0); settle();

    tick_cfg = 2;
    wr(2'd0, 8'd10);
    push(600, 600, 1, "R8 stopped ticks");                        kick(0); settle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule